// File: doc/BRIEF.md
# UART Loopback and Modem Status Unit

This block sits between a UART core and the device pins. In normal operation it passes the serial transmit and receive lines straight through, drives the four modem control outputs from the modem control register, and samples the four modem status inputs through a synchronizer. When the loopback control bit is set, the transmit stream is turned back into the receiver and the transmit pin rests at mark. The control outputs go inactive, and the four status inputs are taken from the low control bits instead of from the pins.

The block also holds the modem status register. Its upper nibble gives the current line levels. Its lower nibble holds sticky change flags, which a read strobe clears. The change flags are ORed together and gated by an enable input to form the modem interrupt request. That request works in both modes, so in loopback, software can raise modem interrupts by writing the control bits.

Top module: `uart_loop_msr`

## Requirements
- R1: With `mcr[4]` = 0, `pin_tx` equals `core_tx` and `core_rx` equals `pin_rx` in the same cycle.
- R2: With `mcr[4]` = 0, `pin_dtr`, `pin_rts`, `pin_out1` and `pin_out2` equal `mcr[0]`, `mcr[1]`, `mcr[2]` and `mcr[3]` respectively.
- R3: With `mcr[4]` = 1, `core_rx` equals `core_tx`, `pin_tx` is 1, and the four control outputs are 0.
- R4: With `mcr[4]` = 1, the status sources are CTS from `mcr[0]`, DSR from `mcr[1]`, RI from `mcr[2]` and DCD from `mcr[3]`. The status pins have no effect. The level bits `msr_q[4]` (CTS), `msr_q[5]` (DSR), `msr_q[6]` (RI) and `msr_q[7]` (DCD) show the source value from the previous cycle.
- R5: With `mcr[4]` = 0, a change on a status pin appears in the level bits after SYNC_STAGES+1 rising clock edges.
- R6: `msr_q[0]`, `msr_q[1]` and `msr_q[3]` become 1 whenever the CTS, DSR or DCD level bit changes value, in the same cycle as the change, and stay set until they are cleared.
- R7: `msr_q[2]` becomes 1 only when the RI level bit goes from 1 to 0. A rise of RI leaves it unchanged.
- R8: A cycle with `msr_rd` = 1 clears `msr_q[3:0]` at the next edge. A change that lands on that same edge still sets its bit.
- R9: `irq` is 1 exactly when `irq_en` is 1 and any of `msr_q[3:0]` is 1.
- R10: While `rst_n` is low, `msr_q` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr | input | 5 | Modem control bits: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback |
| core_tx | input | 1 | Serial output of the UART core |
| core_rx | output | 1 | Serial input to the UART core |
| pin_tx | output | 1 | Transmit pin |
| pin_rx | input | 1 | Receive pin |
| pin_dtr | output | 1 | DTR output pin, active high |
| pin_rts | output | 1 | RTS output pin, active high |
| pin_out1 | output | 1 | OUT1 output pin, active high |
| pin_out2 | output | 1 | OUT2 output pin, active high |
| pin_cts | input | 1 | CTS input pin, active high |
| pin_dsr | input | 1 | DSR input pin, active high |
| pin_ri | input | 1 | RI input pin, active high |
| pin_dcd | input | 1 | DCD input pin, active high |
| msr_rd | input | 1 | Status register read strobe |
| msr_q | output | 8 | Status register: change flags [3:0], levels [7:4] |
| irq_en | input | 1 | Modem interrupt enable |
| irq | output | 1 | Modem interrupt request |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This shows that the pin-to-status latency follows the parameter and is not a fixed two-stage delay. The deeper pipeline also lets a pin change still be in flight when loopback is switched on or off. This tests that a switch of source during the synchronizer window is reported exactly once, as a change of level.

// File: rtl/uart_loop_msr.sv
module uart_loop_msr #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mcr,
  input  logic       core_tx,
  output logic       core_rx,
  output logic       pin_tx,
  input  logic       pin_rx,
  output logic       pin_dtr,
  output logic       pin_rts,
  output logic       pin_out1,
  output logic       pin_out2,
  input  logic       pin_cts,
  input  logic       pin_dsr,
  input  logic       pin_ri,
  input  logic       pin_dcd,
  input  logic       msr_rd,
  output logic [7:0] msr_q,
  input  logic       irq_en,
  output logic       irq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic                        loop;
  logic [3:0]                  ext;
  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0]                  src;
  logic [3:0]                  lvl;
  logic [3:0]                  delta;
  logic [3:0]                  chg;
  logic [3:0]                  evt;

  assign loop = mcr[4];

  assign pin_tx   = loop ? 1'b1 : core_tx;
  assign core_rx  = loop ? core_tx : pin_rx;
  assign pin_dtr  = mcr[0] & ~loop;
  assign pin_rts  = mcr[1] & ~loop;
  assign pin_out1 = mcr[2] & ~loop;
  assign pin_out2 = mcr[3] & ~loop;

  assign ext = {pin_dcd, pin_ri, pin_dsr, pin_cts};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      for (int i = LAST; i > 0; i--) sync_q[i] <= sync_q[i-1];
      sync_q[0] <= ext;
    end
  end

  assign src = loop ? mcr[3:0] : sync_q[LAST];
  assign chg = src ^ lvl;
  assign evt = {chg[3], lvl[2] & ~src[2], chg[1], chg[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= '0;
      delta <= '0;
    end else begin
      lvl   <= src;
      delta <= (msr_rd ? 4'b0 : delta) | evt;
    end
  end

  assign msr_q = {lvl, delta};
  assign irq   = irq_en & |delta;

endmodule

module uart_loop_msr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] mcr,
  input logic       core_tx,
  input logic       core_rx,
  input logic       pin_tx,
  input logic       pin_dtr,
  input logic       pin_rts,
  input logic       pin_out1,
  input logic       pin_out2,
  input logic [7:0] msr_q,
  input logic       irq_en,
  input logic       irq
);

  p_loop_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[4] |-> (pin_tx && core_rx == core_tx &&
                !pin_dtr && !pin_rts && !pin_out1 && !pin_out2));

  p_loop_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[4] |=> msr_q[7:4] == $past(mcr[3:0]));

  p_ri_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_q[2]) |-> $fell(msr_q[6]));

  p_cts_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_q[0]) |-> msr_q[4] != $past(msr_q[4]));

  p_dcd_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_q[3]) |-> msr_q[7] != $past(msr_q[7]));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en && msr_q[3:0] != 4'b0);

endmodule

bind uart_loop_msr uart_loop_msr_chk u_chk (.*);

// File: tb/tb_uart_loop_msr.sv
`timescale 1ns/1ps
module tb_uart_loop_msr;
  localparam int S = 3;

  logic clk = 0, rst_n = 0;
  logic [4:0] mcr = 0;
  logic core_tx = 1, pin_rx = 1, msr_rd = 0, irq_en = 0;
  logic pin_cts = 0, pin_dsr = 0, pin_ri = 0, pin_dcd = 0;
  logic core_rx, pin_tx, pin_dtr, pin_rts, pin_out1, pin_out2, irq;
  logic [7:0] msr_q;

  int checks = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_loop_msr #(.SYNC_STAGES(S)) dut (.*);

  logic [3:0] pipe [S];
  logic [3:0] m_lvl, m_dlt;

  function automatic logic [3:0] events(logic [3:0] old, logic [3:0] nw);
    return {old[3] ^ nw[3], old[2] & ~nw[2], old[1] ^ nw[1], old[0] ^ nw[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < S; i++) pipe[i] <= 0;
      m_lvl <= 0; m_dlt <= 0;
    end else begin
      logic [3:0] s;
      s = mcr[4] ? mcr[3:0] : pipe[S-1];
      for (int i = S-1; i > 0; i--) pipe[i] <= pipe[i-1];
      pipe[0] <= {pin_dcd, pin_ri, pin_dsr, pin_cts};
      m_lvl <= s;
      m_dlt <= (msr_rd ? 4'b0 : m_dlt) | events(m_lvl, s);
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_regs();
    chk(mcr[4] ? "R4 levels" : "R5 levels", {4'b0, msr_q[7:4]}, {4'b0, m_lvl});
    chk("R6 deltas", {5'b0, msr_q[3], msr_q[1:0]}, {5'b0, m_dlt[3], m_dlt[1:0]});
    chk("R7 ri delta", {7'b0, msr_q[2]}, {7'b0, m_dlt[2]});
    chk("R9 irq", {7'b0, irq}, {7'b0, irq_en & |m_dlt});
  endtask

  task automatic chk_comb();
    if (mcr[4]) begin
      chk("R3 loop pins", {2'b0, core_rx, pin_tx, pin_dtr, pin_rts, pin_out1, pin_out2},
          {2'b0, core_tx, 1'b1, 4'b0});
    end else begin
      chk("R1 serial", {6'b0, core_rx, pin_tx}, {6'b0, pin_rx, core_tx});
      chk("R2 control", {4'b0, pin_out2, pin_out1, pin_rts, pin_dtr}, {4'b0, mcr[3:0]});
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk_regs();
    #1 chk_comb();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1ab5));
    repeat (3) @(posedge clk);
    pin_cts = 1; pin_ri = 1; mcr = 5'h0f; irq_en = 1;
    @(negedge clk);
    chk("R10 reset msr", msr_q, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    for (int n = 0; n < 4000; n++) begin
      step();
      if ($urandom_range(99) < 3) mcr[4] = ~mcr[4];
      for (int b = 0; b < 4; b++) if ($urandom_range(9) == 0) mcr[b] = ~mcr[b];
      if ($urandom_range(9) == 0) pin_cts = ~pin_cts;
      if ($urandom_range(9) == 0) pin_dsr = ~pin_dsr;
      if ($urandom_range(9) == 0) pin_ri  = ~pin_ri;
      if ($urandom_range(9) == 0) pin_dcd = ~pin_dcd;
      msr_rd  = ($urandom_range(9) < 3);
      irq_en  = ($urandom_range(9) < 7);
      core_tx = $urandom_range(1);
      pin_rx  = $urandom_range(1);
      #1 chk_comb();
    end
    // directed: loopback, R7 RI edges, R8 read versus new change
    @(negedge clk); mcr = 5'h10; msr_rd = 1; irq_en = 1;
    repeat (3) step();
    msr_rd = 0;
    pin_cts = ~pin_cts; pin_dcd = ~pin_dcd; pin_ri = ~pin_ri;
    repeat (S + 2) step();
    chk("R4 pins ignored", msr_q, 8'h00);
    mcr[2] = 1; step(); step();
    chk("R7 ri rise no flag", msr_q, 8'h40);
    mcr[2] = 0; step();
    chk("R7 ri fall flag", msr_q, 8'h04);
    chk("R9 irq on flag", {7'b0, irq}, 8'h01);
    irq_en = 0; #1;
    chk("R9 irq masked", {7'b0, irq}, 8'h00);
    mcr[0] = 1; msr_rd = 1; step();
    chk("R8 change wins over read", msr_q, 8'h11);
    msr_rd = 1; step();
    msr_rd = 0;
    chk("R8 read clears", msr_q, 8'h10);
    mcr[4] = 0; pin_cts = 1; pin_dsr = 0; pin_ri = 0; pin_dcd = 0;
    repeat (S + 2) step();
    msr_rd = 1; step(); msr_rd = 0; step();
    pin_dsr = 1; #1;
    for (int k = 1; k <= S + 1; k++) begin
      @(negedge clk);
      chk("R5 sync latency", {7'b0, msr_q[5]}, {7'b0, 1'(k == S + 1)});
    end
    chk("R6 dsr flag", {7'b0, msr_q[1]}, 8'h01);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule